// File: doc/BRIEF.md
# JTAG Debug Access Port for an Embedded CPU

This block is a JTAG test access port. Through it a host can control an embedded processor from outside. A 16-state controller advances on rising TCK edges, steered by TMS. A 4-bit instruction register selects which data register sits between TDI and TDO, and each data register has its own length. The data registers are the host's view of the core's emulation interface:

- a halt request and control field;
- an acknowledge/ready status readback;
- an injected-instruction register;
- a bidirectional exchange word;
- a live program-counter readback that can be read while the core runs.

Each time the host commits an injected instruction, the core sees one execute strobe, one system clock wide. The strobe is also raised each time the controller enters Run-Test/Idle with the execute instruction in force. The strobe is handed over from the TCK domain as a toggle through a synchronizer. TDO is launched on falling TCK and, outside the two shift states, is held low. Several ports can be chained TDO to TDI, because each one is a plain shift path whose length depends on its instruction.

Instruction codes:

| Code | Register | Length (bits) |
|------|----------|---------------|
| 0x1 | identity | 32 |
| 0x2 | control/status | CTL_W+2 |
| 0x3 | instruction | INSN_W |
| 0x4 | exchange | DATA_W |
| 0x5 | program counter | PC_W |
| 0x6 | execute | 1 |
| 0xF and every unassigned code | bypass | 1 |

All data registers shift least significant bit first.

Top module: `dbg_tap`

## Requirements
- R1: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. In that state the instruction register is set to the identity code 0x1.
- R2: The controller follows the standard 16-state transition graph. A shift may be suspended through Exit1, Pause and Exit2 and resumed without losing or repeating bits.
- R3: On Capture-IR the instruction shift path loads the pattern 01 in its two low bits and zeros above them, so the first bit out is 1.
- R4: Code 0xF, and every unassigned code, selects a 1-bit bypass register that captures 0. Data therefore emerges one TCK later.
- R5: Code 0x1 selects a 32-bit register that captures the IDCODE_VAL parameter.
- R6: Code 0x2 selects a CTL_W+2 bit register. Capture loads bit 0 = emu_ack, bit 1 = emu_rdy, and bits above = the current emu_ctl. Update drives emu_req from bit 0 and emu_ctl from the bits above bit 1; bit 1 is ignored.
- R7: Code 0x3 selects an INSN_W-bit register. Capture loads the current emu_insn. Update drives emu_insn and produces exactly one execute strobe.
- R8: Code 0x4 selects a DATA_W-bit register. Capture loads xfer_from_core; update drives xfer_to_core.
- R9: Code 0x5 selects a PC_W-bit register that captures core_pc at every Capture-DR. Its update changes no output.
- R10: Each entry into Run-Test/Idle from another state yields one execute strobe when code 0x6 is the instruction in force there. Remaining in Run-Test/Idle yields none.
- R11: emu_exec is never high for two consecutive clk cycles, and it pulses once per execute event.
- R12: TDO changes on falling TCK. It carries the LSB of the selected shift path in Shift-IR and Shift-DR and is 0 in every other state.
- R13: trst_n low at a rising TCK edge returns the controller to Test-Logic-Reset and clears emu_req, emu_ctl, emu_insn and xfer_to_core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core system clock |
| rst_n | input | 1 | Synchronous active-low reset, clk domain |
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low reset, tck domain |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, launched on falling tck |
| emu_req | output | 1 | Request for the core to enter emulation |
| emu_ctl | output | CTL_W | Emulation control field |
| emu_insn | output | INSN_W | Instruction to inject into the core |
| emu_exec | output | 1 | One-clk execute strobe |
| emu_ack | input | 1 | Core reports it is in emulation |
| emu_rdy | input | 1 | Core ready for the next injected instruction |
| xfer_to_core | output | DATA_W | Exchange word, host to core |
| xfer_from_core | input | DATA_W | Exchange word, core to host |
| core_pc | input | PC_W | Live program counter of the core |

## Verification
The hardest case to reach from the pins is a strobe that depends on the instruction register's next value. The trigger is an Update-IR that loads the execute code and falls straight into Run-Test/Idle. The bench drives exactly that path, then holds the controller in Run-Test/Idle, then re-enters it through a short DR scan, and counts strobes after each step. A second hard case is a data scan interrupted in Pause-DR and then resumed. The bench also drives five TMS-high clocks from Pause-DR and afterwards reads the identity register, proving that the instruction register was reset.

// File: rtl/dbg_tap_pkg.sv
// Shared types of the debug access port: controller states, instruction
// codes and the transition function. Assumes a 4-bit instruction register.
package dbg_tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
    localparam logic [IR_W-1:0] OP_CTRL   = 4'h2;
    localparam logic [IR_W-1:0] OP_INSN   = 4'h3;
    localparam logic [IR_W-1:0] OP_DATA   = 4'h4;
    localparam logic [IR_W-1:0] OP_PC     = 4'h5;
    localparam logic [IR_W-1:0] OP_EXEC   = 4'h6;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Next controller state for the current state and TMS level
    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        case (s)
            TS_RESET:  return m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: return m ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: return m ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: return m ? TS_SEL_DR : TS_IDLE;
            default:   return TS_RESET;
        endcase
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
// 16-state test controller. Advances on rising tck according to tms.
// Assumes trst_n is synchronous to tck.
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output tap_state_t state_nx
);

    // Next state from the standard transition graph
    always_comb state_nx = tap_next(state, tms);

    // State register
    always_ff @(posedge tck) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= state_nx;
    end

endmodule

// File: rtl/dbg_tap_ir.sv
// Instruction shift path and instruction register. Captures 01 in the low
// bits and falls back to the identity code in Test-Logic-Reset. Also gives
// the value in force after the current edge so that a consumer can act on
// an instruction updated on the same edge.
module dbg_tap_ir
    import dbg_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_t      state,
    output logic [IR_W-1:0] ir_q,
    output logic [IR_W-1:0] ir_nx,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    // Capture and shift of the instruction path
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sr <= '0;
        else if (state == TS_CAP_IR) ir_sr <= {{(IR_W-2){1'b0}}, 2'b01};
        else if (state == TS_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Instruction in force after this edge
    always_comb begin
        if (state == TS_RESET)       ir_nx = OP_IDCODE;
        else if (state == TS_UPD_IR) ir_nx = ir_sr;
        else                         ir_nx = ir_q;
    end

    // Instruction register
    always_ff @(posedge tck) begin
        if (!trst_n) ir_q <= OP_IDCODE;
        else         ir_q <= ir_nx;
    end

    assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/dbg_tap_dr.sv
// Data shift path whose length follows the instruction, plus the emulation
// registers it updates and the execute toggle. Core inputs are assumed
// stable around a Capture-DR edge.
module dbg_tap_dr
    import dbg_tap_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h1,
    parameter int          INSN_W     = 8,
    parameter int          CTL_W      = 4,
    parameter int          DATA_W     = 32,
    parameter int          PC_W       = 32
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_state_t        state,
    input  tap_state_t        state_nx,
    input  logic [IR_W-1:0]   ir_q,
    input  logic [IR_W-1:0]   ir_nx,
    input  logic              emu_ack,
    input  logic              emu_rdy,
    input  logic [DATA_W-1:0] xfer_from_core,
    input  logic [PC_W-1:0]   core_pc,
    output logic              emu_req,
    output logic [CTL_W-1:0]  emu_ctl,
    output logic [INSN_W-1:0] emu_insn,
    output logic [DATA_W-1:0] xfer_to_core,
    output logic              exec_tog,
    output logic              dr_lsb
);

    localparam int CS_W   = CTL_W + 2;
    localparam int DR_MAX = maxi(maxi(32, CS_W), maxi(maxi(INSN_W, DATA_W), PC_W));

    logic [DR_MAX-1:0] dr_sr, cap_val, shf_val;
    int                len;

    // Length of the selected data register
    always_comb begin
        case (ir_q)
            OP_IDCODE: len = 32;
            OP_CTRL:   len = CS_W;
            OP_INSN:   len = INSN_W;
            OP_DATA:   len = DATA_W;
            OP_PC:     len = PC_W;
            default:   len = 1;
        endcase
    end

    // Value loaded at Capture-DR
    always_comb begin
        cap_val = '0;
        case (ir_q)
            OP_IDCODE: cap_val[31:0]       = IDCODE_VAL;
            OP_CTRL:   cap_val[CS_W-1:0]   = {emu_ctl, emu_rdy, emu_ack};
            OP_INSN:   cap_val[INSN_W-1:0] = emu_insn;
            OP_DATA:   cap_val[DATA_W-1:0] = xfer_from_core;
            OP_PC:     cap_val[PC_W-1:0]   = core_pc;
            default:   cap_val             = '0;
        endcase
    end

    // One shift step: tdi enters at the top bit of the selected length
    always_comb begin
        for (int i = 0; i < DR_MAX; i++) begin
            if (i == len - 1)     shf_val[i] = tdi;
            else if (i < len - 1) shf_val[i] = dr_sr[i+1];
            else                  shf_val[i] = 1'b0;
        end
    end

    // Data shift path
    always_ff @(posedge tck) begin
        if (!trst_n)                 dr_sr <= '0;
        else if (state == TS_CAP_DR) dr_sr <= cap_val;
        else if (state == TS_SH_DR)  dr_sr <= shf_val;
    end

    // Emulation registers written at Update-DR
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            emu_req      <= 1'b0;
            emu_ctl      <= '0;
            emu_insn     <= '0;
            xfer_to_core <= '0;
        end else if (state == TS_UPD_DR) begin
            case (ir_q)
                OP_CTRL: begin
                    emu_req <= dr_sr[0];
                    emu_ctl <= dr_sr[CS_W-1:2];
                end
                OP_INSN: emu_insn     <= dr_sr[INSN_W-1:0];
                OP_DATA: xfer_to_core <= dr_sr[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    // Execute event toggle: instruction committed, or idle entered with the execute code
    always_ff @(posedge tck) begin
        if (!trst_n)
            exec_tog <= 1'b0;
        else if ((state == TS_UPD_DR && ir_q == OP_INSN) ||
                 (state_nx == TS_IDLE && state != TS_IDLE && ir_nx == OP_EXEC))
            exec_tog <= ~exec_tog;
    end

    assign dr_lsb = dr_sr[0];

endmodule

// File: rtl/dbg_tap_exec_sync.sv
// Brings the execute toggle into the clk domain and turns each change into a
// one-cycle strobe. Assumes the toggle changes at most once per four clk cycles.
module dbg_tap_exec_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);

    logic [SYNC_N:0] sync_q;

    // Synchronizer chain plus one stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-1:0], tog_in};
    end

    assign pulse = sync_q[SYNC_N] ^ sync_q[SYNC_N-1];

endmodule

// File: rtl/dbg_tap.sv
// Debug access port top: controller, instruction and data paths, a falling
// edge TDO stage and the execute strobe synchronizer. Assumes tck runs at
// most a quarter of the clk rate.
module dbg_tap
    import dbg_tap_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h2B7A_90E3,
    parameter int          INSN_W     = 8,
    parameter int          CTL_W      = 4,
    parameter int          DATA_W     = 32,
    parameter int          PC_W       = 32,
    parameter int          SYNC_N     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              emu_req,
    output logic [CTL_W-1:0]  emu_ctl,
    output logic [INSN_W-1:0] emu_insn,
    output logic              emu_exec,
    input  logic              emu_ack,
    input  logic              emu_rdy,
    output logic [DATA_W-1:0] xfer_to_core,
    input  logic [DATA_W-1:0] xfer_from_core,
    input  logic [PC_W-1:0]   core_pc
);

    tap_state_t      tap_st, tap_nx;
    logic [IR_W-1:0] ir_q, ir_nx;
    logic            ir_lsb, dr_lsb, exec_tog;

    dbg_tap_fsm i_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_st), .state_nx(tap_nx)
    );

    dbg_tap_ir i_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_st),
        .ir_q(ir_q), .ir_nx(ir_nx), .ir_lsb(ir_lsb)
    );

    dbg_tap_dr #(
        .IDCODE_VAL(IDCODE_VAL), .INSN_W(INSN_W), .CTL_W(CTL_W),
        .DATA_W(DATA_W), .PC_W(PC_W)
    ) i_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_st), .state_nx(tap_nx),
        .ir_q(ir_q), .ir_nx(ir_nx), .emu_ack(emu_ack), .emu_rdy(emu_rdy),
        .xfer_from_core(xfer_from_core), .core_pc(core_pc),
        .emu_req(emu_req), .emu_ctl(emu_ctl), .emu_insn(emu_insn),
        .xfer_to_core(xfer_to_core), .exec_tog(exec_tog), .dr_lsb(dr_lsb)
    );

    dbg_tap_exec_sync #(.SYNC_N(SYNC_N)) i_sync (
        .clk(clk), .rst_n(rst_n), .tog_in(exec_tog), .pulse(emu_exec)
    );

    // TDO launch on falling tck, low outside the shift states
    always_ff @(negedge tck) begin
        if (!trst_n)                tdo <= 1'b0;
        else if (tap_st == TS_SH_IR) tdo <= ir_lsb;
        else if (tap_st == TS_SH_DR) tdo <= dr_lsb;
        else                         tdo <= 1'b0;
    end

endmodule

// File: rtl/dbg_tap_chk.sv
// Property checker for dbg_tap, attached with bind.
module dbg_tap_chk
    import dbg_tap_pkg::*;
#(
    parameter int INSN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tck,
    input logic              trst_n,
    input logic              tms,
    input logic              tdo,
    input tap_state_t        st,
    input logic [IR_W-1:0]   ir,
    input logic              emu_req,
    input logic [INSN_W-1:0] emu_insn,
    input logic              emu_exec
);

    logic [2:0] ones_cnt;

    // Count of consecutive rising tck edges with tms high, saturating
    always_ff @(posedge tck) begin
        if (!trst_n)    ones_cnt <= '0;
        else if (!tms)  ones_cnt <= '0;
        else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
    end

    p_five_ones_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_cnt >= 3'd5) |-> (st == TS_RESET));

    p_reset_loads_id_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TS_RESET) |=> (ir == OP_IDCODE));

    p_tdo_idle_low_r12: assert property (@(posedge tck) disable iff (!trst_n)
        !(st == TS_SH_IR || st == TS_SH_DR) |-> (tdo == 1'b0));

    p_req_on_update_r6: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(emu_req) |-> ($past(st) == TS_UPD_DR || !$past(trst_n)));

    p_insn_on_update_r7: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(emu_insn) |-> ($past(st) == TS_UPD_DR || !$past(trst_n)));

    p_exec_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        emu_exec |=> !emu_exec);

endmodule

bind dbg_tap dbg_tap_chk #(.INSN_W(INSN_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n), .tms(tms), .tdo(tdo),
    .st(tap_st), .ir(ir_q), .emu_req(emu_req), .emu_insn(emu_insn),
    .emu_exec(emu_exec)
);

// File: tb/test_dbg_tap.sv
module test_dbg_tap;
    import dbg_tap_pkg::*;

    localparam time CLK_PERIOD = 10;
    localparam int  IW = 8, CW = 4, DW = 32, PW = 32;
    localparam logic [31:0] IDC = 32'h2B7A_90E3;

    logic clk = 0, rst_n = 0, tck = 0, trst_n = 0, tms = 1, tdi = 0;
    logic tdo, emu_req, emu_exec, emu_ack = 0, emu_rdy = 0;
    logic [CW-1:0] emu_ctl;
    logic [IW-1:0] emu_insn;
    logic [DW-1:0] xfer_to_core, xfer_from_core = '0;
    logic [PW-1:0] core_pc = '0;

    dbg_tap #(.IDCODE_VAL(IDC), .INSN_W(IW), .CTL_W(CW), .DATA_W(DW), .PC_W(PW)) i_dbg_tap (
        .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .emu_req(emu_req), .emu_ctl(emu_ctl), .emu_insn(emu_insn),
        .emu_exec(emu_exec), .emu_ack(emu_ack), .emu_rdy(emu_rdy),
        .xfer_to_core(xfer_to_core), .xfer_from_core(xfer_from_core), .core_pc(core_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0, tdo_cmp = 0, cmp_on = 0;

    // ---------------- behavioural reference model ----------------
    tap_state_t      ms = TS_RESET;
    logic [IR_W-1:0] mir = OP_IDCODE;
    bit              irq[$], drq[$];
    logic            mreq = 0, exp_tdo = 0;
    logic [CW-1:0]   mctl = '0;
    logic [IW-1:0]   mins = '0;
    logic [DW-1:0]   mdo = '0;
    int              mexec = 0, dut_exec = 0, run = 0, max_run = 0;

    function automatic tap_state_t m_next(tap_state_t s, logic m);
        case (s)
            TS_RESET:  m_next = m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   m_next = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: m_next = m ? TS_SEL_IR : TS_CAP_DR;
            TS_SEL_IR: m_next = m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_DR, TS_SH_DR: m_next = m ? TS_EX1_DR : TS_SH_DR;
            TS_CAP_IR, TS_SH_IR: m_next = m ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_DR: m_next = m ? TS_UPD_DR : TS_PAU_DR;
            TS_EX1_IR: m_next = m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_DR: m_next = m ? TS_EX2_DR : TS_PAU_DR;
            TS_PAU_IR: m_next = m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_DR: m_next = m ? TS_UPD_DR : TS_SH_DR;
            TS_EX2_IR: m_next = m ? TS_UPD_IR : TS_SH_IR;
            default:   m_next = m ? TS_SEL_DR : TS_IDLE;
        endcase
    endfunction

    task automatic model_reset();
        ms = TS_RESET; mir = OP_IDCODE; mreq = 0; mctl = '0; mins = '0; mdo = '0;
        irq = {}; drq = {};
    endtask

    task automatic model_rise(logic m, logic d);
        logic [63:0] v; int n; tap_state_t nx;
        v = '0; n = 1;
        case (ms)
            TS_CAP_IR: begin irq = {}; irq.push_back(1); for (int i = 1; i < IR_W; i++) irq.push_back(0); end
            TS_SH_IR:  begin void'(irq.pop_front()); irq.push_back(d); end
            TS_UPD_IR: for (int i = 0; i < IR_W; i++) mir[i] = irq[i];
            TS_CAP_DR: begin
                case (mir)
                    OP_IDCODE: begin v[31:0] = IDC; n = 32; end
                    OP_CTRL:   begin v[CW+1:0] = {mctl, emu_rdy, emu_ack}; n = CW + 2; end
                    OP_INSN:   begin v[IW-1:0] = mins; n = IW; end
                    OP_DATA:   begin v[DW-1:0] = xfer_from_core; n = DW; end
                    OP_PC:     begin v[PW-1:0] = core_pc; n = PW; end
                    default:   begin v = '0; n = 1; end
                endcase
                drq = {};
                for (int i = 0; i < n; i++) drq.push_back(v[i]);
            end
            TS_SH_DR:  begin void'(drq.pop_front()); drq.push_back(d); end
            TS_UPD_DR: begin
                if (mir == OP_CTRL) begin mreq = drq[0]; for (int i = 0; i < CW; i++) mctl[i] = drq[i+2]; end
                if (mir == OP_INSN) begin for (int i = 0; i < IW; i++) mins[i] = drq[i]; mexec++; end
                if (mir == OP_DATA) for (int i = 0; i < DW; i++) mdo[i] = drq[i];
            end
            TS_RESET:  mir = OP_IDCODE;
            default: ;
        endcase
        nx = m_next(ms, m);
        if (nx == TS_IDLE && ms != TS_IDLE && mir == OP_EXEC) mexec++;
        ms = nx;
    endtask

    task automatic model_fall();
        if (ms == TS_SH_IR)      exp_tdo = irq[0];
        else if (ms == TS_SH_DR) exp_tdo = drq[0];
        else                     exp_tdo = 0;
    endtask

    // ---------------- checking helpers ----------------
    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Core-side outputs against the model on every clock
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if ({emu_req, emu_ctl, emu_insn, xfer_to_core} !== {mreq, mctl, mins, mdo}) begin
                errors++;
                $display("FAIL R6/R7/R8 outputs act=%h exp=%h",
                         {emu_req, emu_ctl, emu_insn, xfer_to_core}, {mreq, mctl, mins, mdo});
            end
        end
        if (emu_exec === 1'b1) begin
            dut_exec++; run++;
            if (run > max_run) max_run = run;
        end else run = 0;
    end

    // One tck period; tdo sampled just before the rising edge
    task automatic tbit(input logic m, input logic d, output logic seen);
        tms = m; tdi = d;
        repeat (2) @(posedge clk); #2;
        seen = tdo;
        if (tdo_cmp) begin
            checks++;
            if (tdo !== exp_tdo) begin
                errors++;
                $display("FAIL R12 tdo act=%b exp=%b", tdo, exp_tdo);
            end
        end
        tck = 1;
        if (!trst_n) model_reset(); else model_rise(m, d);
        repeat (2) @(posedge clk); #2;
        tck = 0;
        model_fall();
    endtask

    task automatic step(input logic m);
        logic s; tbit(m, 0, s);
    endtask

    // IR scan from Run-Test/Idle back to Run-Test/Idle
    task automatic scan_ir(input logic [IR_W-1:0] code, output logic [IR_W-1:0] cap);
        logic s;
        step(1); step(1); step(0); step(0);
        for (int i = 0; i < IR_W; i++) begin tbit(i == IR_W-1, code[i], s); cap[i] = s; end
        step(1); step(0);
    endtask

    // DR scan from Run-Test/Idle back to Run-Test/Idle, optional pause midway
    task automatic scan_dr(input int len, input logic [63:0] val, input bit pause, output logic [63:0] cap);
        logic s;
        cap = '0;
        step(1); step(0); step(0);
        for (int i = 0; i < len; i++) begin
            if (pause && i == len/2) begin
                tbit(1, val[i], s); cap[i] = s;
                step(0); step(0); step(0); step(1); step(0);
            end else begin
                tbit(i == len-1, val[i], s); cap[i] = s;
            end
        end
        step(1); step(0);
    endtask

    task automatic settle();
        repeat (12) @(posedge clk); #3;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0]     c;
        logic [IR_W-1:0] ic;
        // reset both domains
        step(1); step(1);
        rst_n = 1; trst_n = 1;
        tdo_cmp = 1; cmp_on = 1;
        chk("R13 tdo after reset", tdo, 0);
        chk("R13 outputs after reset", {emu_req, emu_ctl, emu_insn, xfer_to_core}, 0);
        chk("R11 no strobe after reset", dut_exec, 0);
        step(0);

        // R5 identity register in force after reset
        scan_dr(32, 64'h0, 0, c);
        chk("R5 idcode", c[31:0], IDC);

        // R3 IR capture pattern, R4 bypass
        scan_ir(OP_BYPASS, ic);
        chk("R3 ir capture", ic, 4'b0001);
        scan_dr(8, 64'hA5, 0, c);
        chk("R4 bypass all-ones", c[7:0], 8'h4A);
        scan_ir(4'hC, ic);
        scan_dr(8, 64'h3C, 0, c);
        chk("R4 bypass unassigned", c[7:0], 8'h78);

        // R6 control/status register
        emu_ack = 1; emu_rdy = 0;
        scan_ir(OP_CTRL, ic);
        scan_dr(CW+2, 64'b101011, 0, c);
        chk("R6 capture status", c[CW+1:0], 6'b000001);
        #1 chk("R6 req/ctl written", {emu_req, emu_ctl}, 5'b1_1010);
        emu_ack = 0; emu_rdy = 1;
        scan_dr(CW+2, 64'b000110, 0, c);
        chk("R6 capture ctl readback", c[CW+1:0], 6'b101010);
        #1 chk("R6 bit1 ignored", {emu_req, emu_ctl}, 5'b0_0001);

        // R8 exchange register, R2 with a pause in the middle
        xfer_from_core = 32'h1234_5678;
        scan_ir(OP_DATA, ic);
        scan_dr(32, 64'hCAFE_F00D, 1, c);
        chk("R8 capture (R2 paused)", c[31:0], 32'h1234_5678);
        #1 chk("R8 update (R2 paused)", xfer_to_core, 32'hCAFE_F00D);

        // R9 live program counter
        core_pc = 32'h0000_4A30;
        scan_ir(OP_PC, ic);
        scan_dr(32, 64'hFFFF_FFFF, 0, c);
        chk("R9 pc read", c[31:0], 32'h0000_4A30);
        #1 chk("R9 update ignored", xfer_to_core, 32'hCAFE_F00D);
        core_pc = 32'h0000_4A44;
        scan_dr(32, 64'h0, 0, c);
        chk("R9 pc follows core", c[31:0], 32'h0000_4A44);

        // R13 synchronous test reset mid-run
        trst_n = 0; step(0); trst_n = 1;
        #1 chk("R13 outputs cleared", {emu_req, emu_ctl, emu_insn, xfer_to_core}, 0);
        step(0);
        scan_dr(32, 64'h0, 0, c);
        chk("R13 ir back to idcode", c[31:0], IDC);

        // R7 instruction injection with strobe
        scan_ir(OP_INSN, ic);
        scan_dr(IW, 64'h3C, 0, c);
        chk("R7 capture cleared insn", c[IW-1:0], 0);
        settle();
        chk("R7 insn written", emu_insn, 8'h3C);
        chk("R7 one strobe", dut_exec, 1);
        scan_dr(IW, 64'h81, 0, c);
        chk("R7 capture previous insn", c[IW-1:0], 8'h3C);
        settle();
        chk("R7 second strobe", dut_exec, 2);

        // R10 execute instruction on idle entry
        scan_ir(OP_EXEC, ic);
        settle();
        chk("R10 strobe on update-ir into idle", dut_exec, 3);
        repeat (5) step(0);
        settle();
        chk("R10 no strobe while idle", dut_exec, 3);
        scan_dr(1, 64'h0, 0, c);
        settle();
        chk("R10 strobe on re-entry", dut_exec, 4);
        chk("R11 strobe count vs model", dut_exec, mexec);
        chk("R11 strobe width", max_run, 1);

        // R1 five tms-high clocks from Pause-DR
        scan_ir(OP_CTRL, ic);
        step(1); step(0); step(0); step(1); step(0);
        repeat (5) step(1);
        step(0);
        scan_dr(32, 64'h0, 0, c);
        chk("R1 reset from pause selects idcode", c[31:0], IDC);
        settle();
        chk("R11 final strobe count", dut_exec, mexec);

        done = 1;
        summary();
        $finish;
    end

endmodule